// File: doc/BRIEF.md
# Parallel XOR Random Bitstream Expander

This block turns two independent serial random bit sources into a word of N random bits per accepted clock. Each source shifts into its own chain of N+1 stages. Output bit k is the XOR of one stage from each chain. The stage taken from the first chain gets deeper as k rises, and the stage taken from the second chain gets shallower. Because of this, every output bit in every cycle is built from an (A, B) sample pair that no other bit in any cycle uses. A few shift stages and N XOR gates then give N uncorrelated streams where N separate generators would otherwise be needed.

The entropy sources sit outside the block. They present one bit each together with a shared valid strobe. The chains advance only on strobed cycles. A single-source mode ignores the second input and feeds the tail of the first chain into the head of the second, so that one source drives both chains. The output word is registered and carries a valid flag. The flag rises once enough samples have been accepted to fill every tap the outputs use.

Samples are numbered 0, 1, 2, ... in the order they are accepted after reset. A(s) and B(s) are the bits of sample s. Any sample with a negative number counts as 0.

Top module: `xsr_expander`

## Requirements
- R1: While reset is high, and in the cycle after it is released, rnd_out is all zeros and rnd_valid is low.
- R2: Each cycle with ent_valid high accepts one sample. ent_a enters the head of the A chain. In dual-source mode ent_b enters the head of the B chain. Older samples move one stage deeper.
- R3: On the clock edge that accepts sample s, output bit k (k = 0 for the LSB, up to N-1) takes the value A(s-k-1) XOR B(s-N+k). All N bits update on the same edge.
- R4: In dual-source mode, rnd_valid rises on the edge that accepts sample N, which is the (N+1)th sample. It then stays high until reset.
- R5: In a cycle with ent_valid low, rnd_out, rnd_valid and both chains keep their values. Sample numbering counts only accepted cycles.
- R6: With single_src high, B(s) equals A(s-N-1), and rnd_valid rises on the edge that accepts sample 2N+1. single_src changes only while reset is high.
- R7: With single_src high, ent_b has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ent_a | input | 1 | Bit from random source A |
| ent_b | input | 1 | Bit from random source B (ignored in single-source mode) |
| ent_valid | input | 1 | Both source bits are valid; the chains shift |
| single_src | input | 1 | Single-source mode: chain A tail feeds chain B head |
| rnd_out | output | N | Parallel random output word |
| rnd_valid | output | 1 | Output word is built from real samples only |

## Verification
Long seeded random streams on both inputs, with strobe gaps mixed in, test the full tap equation. A wrong tap or an off-by-one shows up as a mismatch on almost every cycle.

A single 1 sent through chain A alone, and then through chain B alone, walks through the output bits in opposite orders at predictable samples. This separates the A tap positions from the B tap positions and catches reversed or swapped taps. All-ones input on both sources must give a zero word, which exposes a missing XOR term.

Single-source runs drive random noise on ent_b. These confirm that the chained B samples come from A alone, and that the valid flag waits for the longer fill.

// File: rtl/xsr_pkg.sv
package xsr_pkg;
  // Stage of chain A read by output bit k (stage 0 holds the newest sample).
  function automatic int unsigned a_stage(int unsigned k);
    return k;
  endfunction

  // Stage of chain B read by output bit k: taps run opposite to chain A.
  function automatic int unsigned b_stage(int unsigned n, int unsigned k);
    return n - 1 - k;
  endfunction

  // Accepted samples needed before every tap holds a real sample.
  function automatic int unsigned fill_count(int unsigned n, bit single);
    return single ? 2 * n + 2 : n + 1;
  endfunction
endpackage

// File: rtl/xsr_shift_reg.sv
module xsr_shift_reg #(
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [DEPTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[DEPTH-2:0], din};
  end
endmodule

// File: rtl/xsr_xor_array.sv
module xsr_xor_array #(
  parameter int N = 4
) (
  input  logic [N-1:0] a_taps,
  input  logic [N-1:0] b_taps,
  output logic [N-1:0] x
);
  for (genvar k = 0; k < N; k++) begin : g_xor
    assign x[k] = a_taps[xsr_pkg::a_stage(k)] ^ b_taps[xsr_pkg::b_stage(N, k)];
  end
endmodule

// File: rtl/xsr_fill_tracker.sv
module xsr_fill_tracker #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic single_src,
  output logic fill_hit
);
  localparam int CW = $clog2(2 * N + 3);
  localparam logic [CW-1:0] TGT_DUAL   = CW'(xsr_pkg::fill_count(N, 1'b0));
  localparam logic [CW-1:0] TGT_SINGLE = CW'(xsr_pkg::fill_count(N, 1'b1));

  logic [CW-1:0] cnt;
  logic [CW-1:0] target;

  assign target   = single_src ? TGT_SINGLE : TGT_DUAL;
  assign fill_hit = accept && (cnt == target - CW'(1));

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (accept && cnt < target)  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/xsr_expander.sv
module xsr_expander #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ent_a,
  input  logic         ent_b,
  input  logic         ent_valid,
  input  logic         single_src,
  output logic [N-1:0] rnd_out,
  output logic         rnd_valid
);
  localparam int DEPTH = N + 1;

  logic [DEPTH-1:0] a_q;
  logic [DEPTH-1:0] b_q;
  logic             b_head;
  logic [N-1:0]     x_comb;
  logic             fill_hit;

  assign b_head = single_src ? a_q[DEPTH-1] : ent_b;

  xsr_shift_reg #(.DEPTH(DEPTH)) u_chain_a (
    .clk(clk), .rst(rst), .shift_en(ent_valid), .din(ent_a), .q(a_q)
  );

  xsr_shift_reg #(.DEPTH(DEPTH)) u_chain_b (
    .clk(clk), .rst(rst), .shift_en(ent_valid), .din(b_head), .q(b_q)
  );

  xsr_xor_array #(.N(N)) u_xor (
    .a_taps(a_q[N-1:0]), .b_taps(b_q[N-1:0]), .x(x_comb)
  );

  xsr_fill_tracker #(.N(N)) u_fill (
    .clk(clk), .rst(rst), .accept(ent_valid), .single_src(single_src),
    .fill_hit(fill_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_out   <= '0;
      rnd_valid <= 1'b0;
    end else if (ent_valid) begin
      rnd_out <= x_comb;
      if (fill_hit) rnd_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/xsr_expander_chk.sv
module xsr_expander_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         ent_a,
  input logic         ent_b,
  input logic         ent_valid,
  input logic         single_src,
  input logic [N:0]   a_q,
  input logic [N:0]   b_q,
  input logic [N-1:0] rnd_out,
  input logic         rnd_valid
);
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (rnd_out == '0 && !rnd_valid));

  assert_head_a_R2: assert property (@(posedge clk) disable iff (rst)
    ent_valid |=> a_q[0] == $past(ent_a));

  assert_head_b_R2: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && !single_src) |=> b_q[0] == $past(ent_b));

  assert_tail_b_R2: assert property (@(posedge clk) disable iff (rst)
    ent_valid |=> b_q[N] == $past(b_q[N-1]));

  for (genvar k = 0; k < N; k++) begin : g_tap
    assert_tap_R3: assert property (@(posedge clk) disable iff (rst)
      ent_valid |=> rnd_out[k] == ($past(a_q[k]) ^ $past(b_q[N-1-k])));
  end

  assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |=> rnd_valid);

  assert_valid_on_accept_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rnd_valid) |-> $past(ent_valid));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ent_valid |=> ($stable(rnd_out) && $stable(rnd_valid) && $stable(a_q) && $stable(b_q)));

  assert_chain_R6: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && single_src) |=> b_q[0] == $past(a_q[N]));
endmodule

bind xsr_expander xsr_expander_chk #(.N(N)) u_xsr_chk (
  .clk(clk), .rst(rst), .ent_a(ent_a), .ent_b(ent_b), .ent_valid(ent_valid),
  .single_src(single_src), .a_q(a_q), .b_q(b_q), .rnd_out(rnd_out),
  .rnd_valid(rnd_valid)
);

// File: tb/test_xsr_expander.sv
module test_xsr_expander;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ent_a = 1'b0, ent_b = 1'b0, ent_valid = 1'b0, single_src = 1'b0;
  logic [N-1:0] rnd_out;
  logic rnd_valid;

  always #10 clk = ~clk;

  xsr_expander #(.N(N)) i_xsr_expander (
    .clk(clk), .rst(rst), .ent_a(ent_a), .ent_b(ent_b), .ent_valid(ent_valid),
    .single_src(single_src), .rnd_out(rnd_out), .rnd_valid(rnd_valid)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit sa [0:1023];
  bit sb [0:1023];
  int ns = 0;
  bit mode_single = 0;
  logic [N-1:0] last_out;
  logic last_v;
  logic [31:0] seed_a = 32'h1234_5678;
  logic [31:0] seed_b = 32'h9abc_def1;

  function automatic logic [31:0] xs(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic bit get_a(int i);
    return (i < 0) ? 1'b0 : sa[i];
  endfunction

  // B sample as the requirements define it, in either mode.
  function automatic bit get_b(int i);
    if (mode_single) return get_a(i - N - 1);
    return (i < 0) ? 1'b0 : sb[i];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit a, bit b, bit v, string req);
    logic [N-1:0] exp;
    int s;
    int fill;
    @(negedge clk);
    ent_a = a; ent_b = b; ent_valid = v;
    @(posedge clk);
    #1;
    if (v) begin
      sa[ns] = a; sb[ns] = b; s = ns; ns++;
      for (int k = 0; k < N; k++) exp[k] = get_a(s - k - 1) ^ get_b(s - N + k);
      check(rnd_out == exp, req, "rnd_out", int'(rnd_out), int'(exp));
      fill = mode_single ? 2 * N + 2 : N + 1;
      check(rnd_valid == (s >= fill - 1), mode_single ? "R6" : "R4", "rnd_valid",
            int'(rnd_valid), int'(s >= fill - 1));
    end else begin
      check(rnd_out == last_out && rnd_valid == last_v, "R5", "hold",
            int'({rnd_valid, rnd_out}), int'({last_v, last_out}));
    end
    last_out = rnd_out;
    last_v = rnd_valid;
  endtask

  task automatic t_reset(bit single);
    @(negedge clk);
    rst = 1'b1; ent_valid = 1'b0; single_src = single;
    repeat (3) @(posedge clk);
    #1;
    check(rnd_out == '0 && !rnd_valid, "R1", "in reset", int'({rnd_valid, rnd_out}), 0);
    @(negedge clk);
    rst = 1'b0;
    mode_single = single;
    ns = 0;
    @(posedge clk);
    #1;
    check(rnd_out == '0 && !rnd_valid, "R1", "after release", int'({rnd_valid, rnd_out}), 0);
    last_out = rnd_out;
    last_v = rnd_valid;
  endtask

  task automatic t_random(int count, bit gaps, string req);
    for (int i = 0; i < count; i++) begin
      seed_a = xs(seed_a);
      seed_b = xs(seed_b);
      if (gaps && seed_a[7:5] == 3'd0) step(seed_b[3], seed_a[9], 1'b0, "R5");
      step(seed_a[0], seed_b[0], 1'b1, req);
    end
  endtask

  task automatic t_impulse(bit on_a);
    for (int i = 0; i < 3 * N; i++)
      step(on_a && i == 2, !on_a && i == 2, 1'b1, "R2");
  endtask

  task automatic t_all_ones();
    for (int i = 0; i < 2 * N + 2; i++) step(1'b1, 1'b1, 1'b1, "R3");
  endtask

  initial begin
    t_reset(1'b0);
    t_impulse(1'b1);
    t_reset(1'b0);
    t_impulse(1'b0);
    t_reset(1'b0);
    t_all_ones();
    t_reset(1'b0);
    t_random(200, 1'b1, "R3");
    t_reset(1'b1);
    t_random(60, 1'b0, "R7");
    t_reset(1'b1);
    t_random(120, 1'b1, "R6");
    t_reset(1'b0);
    t_random(40, 1'b0, "R3");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule